// File: doc/BRIEF.md
# LUT-Fed Two-Bit Arithmetic Logic Cell

This block is one configurable cell of a soft logic fabric model. It holds four 4-input lookup tables, each programmed by a static 16-bit mask. The tables are grouped into two pairs, and each pair feeds one dedicated full adder. Each adder therefore sums the results of two arbitrary 4-input functions rather than two raw operand bits. The two adders form a 2-bit ripple slice. A carry input and a carry output let cells be chained into wider adders, subtractors and counters.

Each adder position can instead present the combinational output of its lower lookup table. In that mode the carry chain keeps working and the sum bit is discarded. Four output registers capture the two results and the two upper table outputs. They have clock enable, synchronous clear and synchronous load. Clear and load are meant to be shared by many cells, so each register has its own configuration bit for each of them. Every result is offered both unregistered and registered at the same time.

Top module: `lut_arith_cell`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four registers clear to 0, so `y_reg` reads 4'b0000.
- R2: Every lookup table outputs bit `mask[{y,x,b,a}]` of its mask, with `shr_a` as index bit 0, `shr_b` as bit 1, the pair's `pair_x` bit as bit 2 and the pair's `pair_y` bit as bit 3. `cfg_mask[2k]` is the lower table of pair k and `cfg_mask[2k+1]` is the upper table of pair k.
- R3: Pair k adds its lower table output, its upper table output and a carry. `carry_in` enters pair 0, the carry of pair 0 enters pair 1, and the carry of pair 1 leaves as `carry_out`.
- R4: When cells are chained carry-to-carry, with tables set to pass `x` and either `y` or `y XOR shr_a`, the chain computes an exact multi-bit sum or difference, including the final carry.
- R5: When `cfg_comb[k]` is 1, `y_comb[k]` shows the lower table output of pair k instead of the sum. The carry chain and `carry_out` are unchanged.
- R6: `y_comb[1:0]` are the two pair results and `y_comb[3:2]` are the upper table outputs of pairs 0 and 1. `y_reg[i]` shows the value `y_comb[i]` had at the previous enabled capture edge.
- R7: Register i clears to 0 when `sclr` is high and `cfg_sclr_en[i]` is 1. This has the highest priority and does not depend on `ce`. With `cfg_sclr_en[i]` at 0, `sclr` has no effect on register i.
- R8: If register i is not cleared, it takes `ld_data[i]` when `sload` is high and `cfg_sload_en[i]` is 1. This does not depend on `ce`. With `cfg_sload_en[i]` at 0, `sload` has no effect on register i.
- R9: If register i is neither cleared nor loaded, it captures `y_comb[i]` when `ce` is high and holds its value when `ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shr_a | input | 1 | Table input shared by all four tables (index bit 0) |
| shr_b | input | 1 | Table input shared by all four tables (index bit 1) |
| pair_x | input | 2 | Per-pair table input, bit k to pair k (index bit 2) |
| pair_y | input | 2 | Per-pair table input, bit k to pair k (index bit 3) |
| cfg_mask | input | 4x16 | Table masks: entry 2k is the lower and entry 2k+1 the upper table of pair k |
| cfg_comb | input | 2 | Per pair: 1 shows the lower table output instead of the sum |
| cfg_sclr_en | input | 4 | Per register: obey `sclr` |
| cfg_sload_en | input | 4 | Per register: obey `sload` |
| ce | input | 1 | Clock enable for capture |
| sclr | input | 1 | Shared synchronous clear |
| sload | input | 1 | Shared synchronous load |
| ld_data | input | 4 | Per-register load value |
| carry_in | input | 1 | Carry into pair 0 |
| carry_out | output | 1 | Carry out of pair 1 |
| y_comb | output | 4 | Unregistered results |
| y_reg | output | 4 | Registered results |

## Verification
The bench chains four cells into an 8-bit datapath. It drives sums that ripple a carry across every cell boundary, such as 0xFF+0x01. A carry that is dropped or routed into the wrong pair would give a wrong high byte or a wrong `carry_out`. Subtraction and counting down depend on the upper table inverting `y` under `shr_a`. A wrong mask index order would break these and also the full 16-entry sweep of one table. The register checks apply clear and load together with mixed per-register enables while `ce` is low. A wrong priority, a clear or load that ignores its enable bit, or a capture that ignores `ce` each leaves a visibly wrong nibble. Combinational mode is checked with carries still rippling, so a design that also muted the carry would fail.

// File: rtl/lut_arith_pkg.sv
// Shared sizing for the LUT-fed arithmetic cell.
// Assumes every table has the same input count; one mask bit per index value.
package lut_arith_pkg;
    localparam int LUT_IN   = 4;
    localparam int MASK_W   = 1 << LUT_IN;
    localparam int NUM_PAIR = 2;
    localparam int NUM_LUT  = 2 * NUM_PAIR;
    localparam int NUM_REG  = 2 * NUM_PAIR;

    typedef logic [MASK_W-1:0] lut_mask_t;

    // Outputs of one table pair plus its adder.
    typedef struct packed {
        logic lo;    // lower table output
        logic hi;    // upper table output
        logic sum;   // raw adder sum
        logic res;   // sum or lower table, per mode
        logic cout;  // adder carry out
    } pair_out_t;
endpackage

// File: rtl/lut4_eval.sv
// One lookup table: returns the mask bit selected by the input vector.
// Assumes the mask is static configuration; sel[0] is the least significant index bit.
module lut4_eval #(
    parameter int N_IN = 4,
    localparam int MW  = 1 << N_IN
) (
    input  logic [N_IN-1:0] sel,
    input  logic [MW-1:0]   mask,
    output logic            f
);
    // Select one bit of the mask.
    always_comb f = mask[sel];
endmodule

// File: rtl/arith_pair.sv
// A pair of lookup tables feeding one full adder, with a result mode mux.
// Assumes both tables see the same four inputs {y, x, b, a}; only the masks differ.
module arith_pair
    import lut_arith_pkg::*;
(
    input  logic      shr_a,
    input  logic      shr_b,
    input  logic      px,
    input  logic      py,
    input  lut_mask_t mask_lo,
    input  lut_mask_t mask_hi,
    input  logic      comb_mode,
    input  logic      cin,
    output pair_out_t po
);
    logic [LUT_IN-1:0] idx;
    logic [1:0]        fout;
    lut_mask_t         masks [2];

    // Build the shared table index and the mask list.
    always_comb begin
        idx      = {py, px, shr_b, shr_a};
        masks[0] = mask_lo;
        masks[1] = mask_hi;
    end

    generate
        for (genvar t = 0; t < 2; t++) begin : g_lut
            lut4_eval #(.N_IN(LUT_IN)) i_lut (
                .sel  (idx),
                .mask (masks[t]),
                .f    (fout[t])
            );
        end
    endgenerate

    // Full adder on the two table outputs and the mode mux on the result.
    always_comb begin
        po.lo   = fout[0];
        po.hi   = fout[1];
        po.sum  = fout[0] ^ fout[1] ^ cin;
        po.cout = (fout[0] & fout[1]) | (cin & (fout[0] ^ fout[1]));
        po.res  = comb_mode ? fout[0] : po.sum;
    end
endmodule

// File: rtl/cell_reg.sv
// One output register with clear, load and clock enable, in that priority.
// Assumes clear and load are shared strobes gated here by per-register enables.
module cell_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sclr,
    input  logic sload,
    input  logic sclr_en,
    input  logic sload_en,
    input  logic ld,
    input  logic d,
    output logic q
);
    logic clr_hit;
    logic load_hit;

    // Gate the shared strobes by this register's enable bits.
    always_comb begin
        clr_hit  = sclr & sclr_en;
        load_hit = sload & sload_en;
    end

    // Register update: reset, then clear, then load, then enabled capture.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (clr_hit)  q <= 1'b0;
        else if (load_hit) q <= ld;
        else if (ce)       q <= d;
    end

    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> q == 1'b0);
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sclr && sclr_en) |=> q == 1'b0);
    a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sclr && sclr_en) && sload && sload_en) |=> q == $past(ld));
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !(sclr && sclr_en) && !(sload && sload_en)) |=> $stable(q));
endmodule

// File: rtl/lut_arith_cell.sv
// Two-bit arithmetic logic cell: two table pairs, a rippled carry and four registers.
// Assumes static configuration inputs; chained through carry_in / carry_out.
module lut_arith_cell
    import lut_arith_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   shr_a,
    input  logic                   shr_b,
    input  logic [1:0]             pair_x,
    input  logic [1:0]             pair_y,
    input  logic [3:0][15:0]       cfg_mask,
    input  logic [1:0]             cfg_comb,
    input  logic [3:0]             cfg_sclr_en,
    input  logic [3:0]             cfg_sload_en,
    input  logic                   ce,
    input  logic                   sclr,
    input  logic                   sload,
    input  logic [3:0]             ld_data,
    input  logic                   carry_in,
    output logic                   carry_out,
    output logic [3:0]             y_comb,
    output logic [3:0]             y_reg
);
    logic [NUM_PAIR:0]   chain;
    pair_out_t           pout [NUM_PAIR];

    assign chain[0]  = carry_in;
    assign carry_out = chain[NUM_PAIR];

    generate
        for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
            arith_pair i_pair (
                .shr_a     (shr_a),
                .shr_b     (shr_b),
                .px        (pair_x[k]),
                .py        (pair_y[k]),
                .mask_lo   (cfg_mask[2*k]),
                .mask_hi   (cfg_mask[2*k+1]),
                .comb_mode (cfg_comb[k]),
                .cin       (chain[k]),
                .po        (pout[k])
            );
            assign chain[k+1]          = pout[k].cout;
            assign y_comb[k]           = pout[k].res;
            assign y_comb[NUM_PAIR+k]  = pout[k].hi;
        end

        for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
            cell_reg i_reg (
                .clk      (clk),
                .rst_n    (rst_n),
                .ce       (ce),
                .sclr     (sclr),
                .sload    (sload),
                .sclr_en  (cfg_sclr_en[r]),
                .sload_en (cfg_sload_en[r]),
                .ld       (ld_data[r]),
                .d        (y_comb[r]),
                .q        (y_reg[r])
            );
        end
    endgenerate

    // R3: the two adders together form a 2-bit add of the table outputs.
    a_r3_two_bit_chain: assert property (@(posedge clk) disable iff (!rst_n)
        {carry_out, pout[1].sum, pout[0].sum} ==
        ({2'b00, pout[0].lo} + {2'b00, pout[0].hi} + {2'b00, carry_in}
         + {1'b0, pout[1].lo, 1'b0} + {1'b0, pout[1].hi, 1'b0}));
    // R5: in combinational mode the result follows the lower table.
    a_r5_comb_pair0: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_comb[0] |-> y_comb[0] == pout[0].lo);
endmodule

// File: tb/test_lut_arith_cell.sv
`timescale 1ns/1ps
// Directed bench: four chained cells form an 8-bit adder and counter.
module test_lut_arith_cell;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shr_a = 1'b0, shr_b = 1'b0;
    logic [NC-1:0][1:0] px_drv = '0, py_drv = '0;
    logic fb = 1'b0;
    logic [3:0][15:0] mask = '0;
    logic [1:0] comb = '0;
    logic [3:0] sclr_en = '0, sload_en = '0;
    logic ce = 1'b0, sclr = 1'b0, sload = 1'b0;
    logic [NC-1:0][3:0] ld = '0;
    logic cin = 1'b0;
    logic [NC:0] cy;
    logic [NC-1:0][3:0] yc, yr;
    logic [NC-1:0][1:0] px_in;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;
    assign cy[0] = cin;

    generate
        for (genvar i = 0; i < NC; i++) begin : g_cell
            assign px_in[i] = fb ? yr[i][1:0] : px_drv[i];
            lut_arith_cell i_lut_arith_cell (
                .clk(clk), .rst_n(rst_n), .shr_a(shr_a), .shr_b(shr_b),
                .pair_x(px_in[i]), .pair_y(py_drv[i]), .cfg_mask(mask),
                .cfg_comb(comb), .cfg_sclr_en(sclr_en), .cfg_sload_en(sload_en),
                .ce(ce), .sclr(sclr), .sload(sload), .ld_data(ld[i]),
                .carry_in(cy[i]), .carry_out(cy[i+1]),
                .y_comb(yc[i]), .y_reg(yr[i]));
        end
    endgenerate

    function automatic logic [15:0] mk(int kind);
        logic [15:0] m;
        for (int i = 0; i < 16; i++) begin
            logic [3:0] j;
            j = 4'(i);
            m[i] = (kind == 0) ? j[2] : (j[3] ^ j[0]);
        end
        return m;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] res8();
        logic [7:0] v;
        for (int i = 0; i < NC; i++) v[2*i +: 2] = yc[i][1:0];
        return v;
    endfunction

    function automatic logic [7:0] reg8();
        logic [7:0] v;
        for (int i = 0; i < NC; i++) v[2*i +: 2] = yr[i][1:0];
        return v;
    endfunction

    task automatic drive_ops(logic [7:0] a, logic [7:0] b);
        for (int i = 0; i < NC; i++) begin
            px_drv[i] = a[2*i +: 2];
            py_drv[i] = b[2*i +: 2];
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < NC; i++) chk("R1 reset state", yr[i], 4'h0);
    endtask

    task automatic t_lut_sweep();
        logic [15:0] pat = 16'hA5C3;
        mask[1] = pat;
        fb = 1'b0;
        for (int idx = 0; idx < 16; idx++) begin
            logic [3:0] j;
            j = 4'(idx);
            @(negedge clk);
            shr_a = j[0]; shr_b = j[1];
            px_drv[0][0] = j[2]; py_drv[0][0] = j[3];
            #1;
            chk("R2 table index", yc[0][2], pat[idx]);
        end
        mask[1] = mk(1);
        shr_b = 1'b0;
    endtask

    task automatic t_add(logic [7:0] a, logic [7:0] b, logic sub, logic c0);
        logic [8:0] exp;
        @(negedge clk);
        fb = 1'b0; shr_a = sub; cin = c0;
        drive_ops(a, b);
        #1;
        exp = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {8'h00, c0};
        chk("R3 R4 chained sum", {23'h0, cy[NC], res8()}, {23'h0, exp});
    endtask

    task automatic t_comb_mode();
        logic [8:0] exp;
        @(negedge clk);
        comb = 2'b11; fb = 1'b0; shr_a = 1'b0; cin = 1'b1;
        drive_ops(8'h5A, 8'hA6);
        #1;
        exp = 9'h05A + 9'h0A6 + 9'h001;
        chk("R5 result shows lower table", res8(), 8'h5A);
        chk("R5 carry unchanged", cy[NC], exp[8]);
        @(negedge clk);
        comb = 2'b00;
    endtask

    task automatic t_counter();
        logic [7:0] model = 8'hFE;
        @(negedge clk);
        fb = 1'b0; sload_en = 4'hF; sload = 1'b1;
        for (int i = 0; i < NC; i++) ld[i] = {2'b00, model[2*i +: 2]};
        drive_ops(8'h00, 8'h00);
        @(negedge clk);
        sload = 1'b0; sload_en = 4'h0;
        chk("R8 counter preload", reg8(), model);
        fb = 1'b1; ce = 1'b1; shr_a = 1'b0; cin = 1'b1;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            model = model + 8'h01;
            chk("R6 R9 count up", reg8(), model);
        end
        shr_a = 1'b1; cin = 1'b0;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            model = model - 8'h01;
            chk("R6 R9 count down", reg8(), model);
        end
        ce = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 hold when ce low", reg8(), model);
        fb = 1'b0;
    endtask

    task automatic t_ctrl();
        @(negedge clk);
        ce = 1'b0; sload_en = 4'hF; sload = 1'b1; ld[0] = 4'b1001;
        @(negedge clk);
        chk("R8 load all", yr[0], 4'b1001);
        sclr_en = 4'b0101; sload_en = 4'b0011; sclr = 1'b1; ld[0] = 4'b1111;
        @(negedge clk);
        chk("R7 R8 priority and per-register enables", yr[0], 4'b1010);
        sclr_en = 4'b0000; sload_en = 4'b0000;
        @(negedge clk);
        chk("R7 R8 disabled strobes ignored", yr[0], 4'b1010);
        sclr = 1'b0; sload = 1'b0;
        shr_a = 1'b0; cin = 1'b0; drive_ops(8'h01, 8'h02);
        ce = 1'b1;
        @(negedge clk);
        ce = 1'b0;
        chk("R6 capture of y_comb", yr[0], {1'b1, 1'b0, 2'b11});
    endtask

    initial begin
        mask[0] = mk(0); mask[1] = mk(1); mask[2] = mk(0); mask[3] = mk(1);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_lut_sweep();
        t_add(8'h12, 8'h34, 1'b0, 1'b0);
        t_add(8'hFF, 8'h01, 1'b0, 1'b0);
        t_add(8'h7F, 8'h80, 1'b0, 1'b1);
        t_add(8'h55, 8'hAA, 1'b0, 1'b0);
        t_add(8'h40, 8'h41, 1'b1, 1'b1);
        t_add(8'hC8, 8'h37, 1'b1, 1'b1);
        t_comb_mode();
        t_counter();
        t_ctrl();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule